// File: doc/BRIEF.md
# Event-Locked Sample Ring with Peak-Centred Window Readout

The block records the 12-bit digitized samples of one channel into a 2048-cell circular memory, one cell per accepted sample. A single-cycle trigger pulse marks an event. The block then searches a programmable span of the most recent samples for the largest value and streams out only a programmable window of cells around that peak. Each output word carries the cell address, the sample value and an end-of-window flag, on a valid/ready handshake. Recording goes on in the free part of the ring while an event is searched and read. One further event can wait behind the one being read, and its peak search may run during the current readout.

Cells that an unread event still needs are protected. Once an event is taken, every cell from the start of its window region up to the write position is protected. The writer stalls in front of that region instead of overwriting it, and it shows this with a busy output. Triggers that arrive while both event slots are occupied are dropped and counted in a saturating counter. Configuration inputs are expected to stay constant while an event is in flight. The search span must lie in 1..64, and at least span + pre samples must have been recorded before the first trigger.

Top module: `roi_capture_buf`

## Requirements
- R1: After a synchronous active-low reset, out_valid, busy and lost_cnt are all 0, and the first accepted sample is written to address 0.
- R2: Each accepted sample (smp_valid high and busy low) goes to the address after the previous one, wrapping from 2047 to 0. A trigger refers to the address offered in its own cycle (tp), and every address computed from tp wraps modulo 2048.
- R3: The peak of an event is the cell holding the largest value among the cfg_span samples at addresses tp-cfg_span to tp-1, with cfg_span in 1..64. When several cells hold the maximum, the lowest of these addresses in arrival order wins.
- R4: The readout of an event is the cells from peak-cfg_pre to peak+cfg_post in ascending address order, each sent once as out_addr (11 bits) and out_data (12 bits), with cfg_pre and cfg_post in 0..63. No word appears outside an event window.
- R5: out_last is 1 on the final word of a window and 0 on every other word.
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_addr, out_data and out_last stay unchanged.
- R7: A trigger that arrives while one event is held is queued. A trigger that arrives while two events are held is dropped, and lost_cnt (8 bits) increments, saturating at 255. A trigger accepted while no event is held starts an event.
- R8: A queued event is read out directly after the current one, with its own peak and window and the same ordering rules.
- R9: While an event is held, the writer never overwrites a cell at or after the start of that event's window region, which is tp-cfg_span-cfg_pre. When the next write would reach that region, busy is 1 and offered samples are dropped. After tp, exactly 2047-cfg_span-cfg_pre samples are accepted before the stall. busy returns to 0 once the event holding the region has been read out.
- R10: A window cell that has not yet been recorded (a cell after the peak) is only sent after the sample for it has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample offered this cycle |
| smp_data | input | 12 | Sample value |
| trig | input | 1 | Single-cycle event marker |
| cfg_span | input | 7 | Number of recent samples searched for the peak (1..64) |
| cfg_pre | input | 6 | Cells sent before the peak |
| cfg_post | input | 6 | Cells sent after the peak |
| out_ready | input | 1 | Consumer accepts the output word |
| out_valid | output | 1 | Output word present |
| out_addr | output | 11 | Ring address of the output sample |
| out_data | output | 12 | Output sample value |
| out_last | output | 1 | Final word of a window |
| busy | output | 1 | Writer stalled by protected cells |
| lost_cnt | output | 8 | Saturating count of dropped triggers |

## Verification
The bench sweeps span, pre and post over small and extreme values against a data pattern that has many repeated maxima. A search that kept the latest tie, or that was off by one cell, would therefore send a window shifted from the expected one. Windows are placed where both the search span and the window end cross the 2047-to-0 boundary, which exposes address arithmetic that does not wrap. With a span of one and a long post, the window runs ahead of the writer, so a reader that does not wait would send stale cells. A long stall of the consumer fills the ring: a broken guard would show as the wrong accepted-sample count before busy, or as corrupted data in the held windows once readout resumes. The same stall, with hundreds of extra triggers, checks that the queued window follows in order and that the lost counter saturates.

// File: rtl/roi_pkg.sv
// Shared constants and types for the event-locked sample ring.
// Assumes one channel and a power-of-two ring depth.
package roi_pkg;
    localparam int DEPTH  = 2048;
    localparam int SMP_W  = 12;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int NMAX   = 64;
    localparam int SPAN_W = $clog2(NMAX) + 1;
    localparam int WIN_W  = 6;
    localparam int LOST_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SMP_W-1:0]  smp_t;

    // One event slot: trigger point, start of protected region, peak cell.
    typedef struct packed {
        logic  live;
        logic  found;
        addr_t tp;
        addr_t lo;
        addr_t pk;
    } evt_t;
endpackage

// File: rtl/roi_ring.sv
// Circular sample memory with a single write pointer and two
// asynchronous read ports (peak search and window readout).
// Assumes the caller raises stall before the writer could enter cells
// that are still needed.
module roi_ring
    import roi_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_req,
    input  smp_t  wr_data,
    input  logic  stall,
    output addr_t wr_ptr,
    input  addr_t ra_addr,
    output smp_t  ra_data,
    input  addr_t rb_addr,
    output smp_t  rb_data
);
    smp_t cells [DEPTH];
    logic wr_fire;

    assign wr_fire = rst_n && wr_req && !stall;

    // Store the accepted sample at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_fire) cells[wr_ptr] <= wr_data;
    end

    // Advance the write pointer on every accepted sample; wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_ptr <= '0;
        else if (wr_fire) wr_ptr <= wr_ptr + 1'b1;
    end

    assign ra_data = cells[ra_addr];
    assign rb_data = cells[rb_addr];
endmodule

// File: rtl/roi_peak.sv
// Sequential maximum search over n consecutive cells starting at base,
// one cell per cycle, oldest first. Ties keep the earliest cell.
// Assumes 1 <= n <= NMAX and that start is ignored while a search runs.
module roi_peak
    import roi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  addr_t             base,
    input  logic [SPAN_W-1:0] n,
    output addr_t             rd_addr,
    input  smp_t              rd_data,
    output logic              active,
    output logic              fin,
    output addr_t             res
);
    logic [SPAN_W-1:0] cnt, n_q;
    addr_t             base_q, best_at;
    smp_t              best;
    logic              take;

    assign rd_addr = base_q + addr_t'(cnt);
    assign take    = (cnt == '0) || (rd_data > best);
    assign fin     = active && (cnt == n_q - 1'b1);
    assign res     = take ? rd_addr : best_at;

    // Run the scan: latch the span on start, keep the best so far.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cnt     <= '0;
            n_q     <= '0;
            base_q  <= '0;
            best    <= '0;
            best_at <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                cnt    <= '0;
                base_q <= base;
                n_q    <= n;
            end
        end else begin
            if (take) begin
                best    <= rd_data;
                best_at <= rd_addr;
            end
            if (fin) active <= 1'b0;
            else     cnt    <= cnt + 1'b1;
        end
    end

    // R3: a span outside 1..NMAX is never launched.
    a_r3_span_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !active) |-> (n >= SPAN_W'(1) && n <= SPAN_W'(NMAX)));

    // R3: the reported peak lies inside the scanned span.
    a_r3_in_span: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (addr_t'(res - base_q) < addr_t'(n_q)));
endmodule

// File: rtl/roi_window.sv
// Streams cells peak-pre .. peak+post through a one-word output register
// with valid/ready. A cell is fetched only once the writer has passed it
// (it lies between the protected-region start lo and the write pointer).
// Assumes start is ignored while a window is being sent.
module roi_window
    import roi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  addr_t            peak,
    input  logic [WIN_W-1:0] pre,
    input  logic [WIN_W-1:0] post,
    input  addr_t            lo,
    input  addr_t            wp,
    output addr_t            rd_addr,
    input  smp_t             rd_data,
    output logic             active,
    output logic             done,
    input  logic             out_ready,
    output logic             out_valid,
    output addr_t            out_addr,
    output smp_t             out_data,
    output logic             out_last
);
    logic [WIN_W:0] left;
    logic           avail, load;

    // Is the next cell already recorded, seen from the region start?
    always_comb begin
        avail = addr_t'(rd_addr - lo) < addr_t'(wp - lo);
        load  = active && avail && (!out_valid || out_ready);
        done  = load && (left == '0);
    end

    // Walk the window addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            rd_addr <= '0;
            left    <= '0;
        end else if (!active) begin
            if (start) begin
                active  <= 1'b1;
                rd_addr <= peak - addr_t'(pre);
                left    <= {1'b0, pre} + {1'b0, post};
            end
        end else if (load) begin
            rd_addr <= rd_addr + 1'b1;
            left    <= left - 1'b1;
            if (left == '0) active <= 1'b0;
        end
    end

    // Output register: load a fetched cell, clear on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_addr  <= rd_addr;
            out_data  <= rd_data;
            out_last  <= (left == '0);
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R6: a stalled word does not change.
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                       && $stable(out_data) && $stable(out_last)));

    // R4: a non-final word is only pending while its window is still open.
    a_r4_run_open: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> active);
endmodule

// File: rtl/roi_capture_buf.sv
// Top of the event-locked sample ring. Holds two event slots (current and
// queued), routes the peak search and the window reader, computes the
// protected-region stall and counts dropped triggers.
// Assumes cfg_* are stable while an event is held and cfg_span is 1..64.
module roi_capture_buf
    import roi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic              trig,
    input  logic [SPAN_W-1:0] cfg_span,
    input  logic [WIN_W-1:0]  cfg_pre,
    input  logic [WIN_W-1:0]  cfg_post,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [SMP_W-1:0]  out_data,
    output logic              out_last,
    output logic              busy,
    output logic [LOST_W-1:0] lost_cnt
);
    evt_t  a_q, p_q, a_d, p_d, fresh;
    addr_t wp, srch_addr, srch_res, srch_tp, win_addr;
    smp_t  srch_data, win_data;
    logic  want_a, want_p, srch_act, srch_fin, win_act, win_done, lost_hit;

    // Stall the writer when its next cell would be the protected-region start.
    assign busy = a_q.live && (addr_t'(wp + 1'b1) == a_q.lo);

    roi_ring u_ring (
        .clk(clk), .rst_n(rst_n), .wr_req(smp_valid), .wr_data(smp_data),
        .stall(busy), .wr_ptr(wp),
        .ra_addr(srch_addr), .ra_data(srch_data),
        .rb_addr(win_addr), .rb_data(win_data)
    );

    // Pick the oldest slot that still lacks a peak.
    always_comb begin
        want_a  = a_q.live && !a_q.found;
        want_p  = p_q.live && !p_q.found;
        srch_tp = want_a ? a_q.tp : p_q.tp;
    end

    roi_peak u_peak (
        .clk(clk), .rst_n(rst_n), .start(want_a || want_p),
        .base(srch_tp - addr_t'(cfg_span)), .n(cfg_span),
        .rd_addr(srch_addr), .rd_data(srch_data),
        .active(srch_act), .fin(srch_fin), .res(srch_res)
    );

    roi_window u_win (
        .clk(clk), .rst_n(rst_n), .start(a_q.live && a_q.found),
        .peak(a_q.pk), .pre(cfg_pre), .post(cfg_post),
        .lo(a_q.lo), .wp(wp), .rd_addr(win_addr), .rd_data(win_data),
        .active(win_act), .done(win_done), .out_ready(out_ready),
        .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data),
        .out_last(out_last)
    );

    // Next slot contents: record a peak, retire a read event, take a trigger.
    always_comb begin
        fresh       = '0;
        fresh.live  = 1'b1;
        fresh.tp    = wp;
        fresh.lo    = wp - addr_t'(cfg_span) - addr_t'(cfg_pre);
        a_d         = a_q;
        p_d         = p_q;
        lost_hit    = 1'b0;
        if (srch_fin) begin
            if (want_a) begin a_d.found = 1'b1; a_d.pk = srch_res; end
            else        begin p_d.found = 1'b1; p_d.pk = srch_res; end
        end
        if (win_done) begin
            a_d = p_d;
            p_d = '0;
        end
        if (trig) begin
            if (!a_d.live)      a_d = fresh;
            else if (!p_d.live) p_d = fresh;
            else                lost_hit = 1'b1;
        end
    end

    // Slot registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            p_q <= '0;
        end else begin
            a_q <= a_d;
            p_q <= p_d;
        end
    end

    // Saturating count of dropped triggers.
    always_ff @(posedge clk) begin
        if (!rst_n)                         lost_cnt <= '0;
        else if (lost_hit && lost_cnt != '1) lost_cnt <= lost_cnt + 1'b1;
    end

    // R7: the queued slot is only occupied behind a current event.
    a_r7_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.live |-> a_q.live);

    // R7: no trigger is counted lost while a slot is free.
    a_r7_no_loss_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !(a_q.live && p_q.live)) |=> (lost_cnt == $past(lost_cnt)));

    // R9: the writer never stands on the protected-region start.
    a_r9_arc_kept: assert property (@(posedge clk) disable iff (!rst_n)
        a_q.live |-> (wp != a_q.lo));

    // R9: no stall without a held event.
    a_r9_busy_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        !a_q.live |-> !busy);

    // R3/R8: the window reader never runs on an event without a peak.
    a_r8_read_after_search: assert property (@(posedge clk) disable iff (!rst_n)
        win_act |-> (a_q.live && a_q.found));
endmodule

// File: tb/roi_capture_buf_bench.sv
module roi_capture_buf_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_valid, trig, out_ready;
    logic [11:0] smp_data;
    logic [6:0]  cfg_span;
    logic [5:0]  cfg_pre, cfg_post;
    logic        out_valid, out_last, busy;
    logic [10:0] out_addr;
    logic [11:0] out_data;
    logic [7:0]  lost_cnt;

    always #5 clk = ~clk;

    roi_capture_buf u_roi_capture_buf (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .trig(trig), .cfg_span(cfg_span), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
        .out_ready(out_ready), .out_valid(out_valid), .out_addr(out_addr),
        .out_data(out_data), .out_last(out_last), .busy(busy), .lost_cnt(lost_cnt)
    );

    int    tests = 0, fails = 0, widx = 0, ncyc = 0, rdy_mode = 0;
    bit    finished = 0;
    int    exp_addr [8192];
    int    exp_data [8192];
    bit    exp_last [8192];
    string exp_tag  [8192];
    int    eh = 0, et = 0;
    bit    hold_pend = 0;
    int    h_addr, h_data;
    bit    h_last;

    // Sample value for absolute sample index i: tie-heavy and hashed bands.
    function automatic int fval(input int i);
        if (((i / 512) % 2) == 0) return ((i * 13) % 29) * 128;
        return (i * 1103 + (i / 4) * 977 + (i % 7) * 401) % 4096;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock: drive inputs at the falling edge, observe registered outputs.
    task automatic cyc(input bit tg);
        smp_valid = 1'b1;
        smp_data  = 12'(fval(widx));
        trig      = tg;
        out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (ncyc % 3 != 0) : 1'b0;
        if (hold_pend) begin
            chk(out_valid, "R6 valid held", int'(out_valid), 1);
            chk(out_addr == 11'(h_addr) && out_data == 12'(h_data) && out_last == h_last,
                "R6 word held", int'(out_addr), h_addr);
        end
        hold_pend = out_valid && !out_ready;
        h_addr = int'(out_addr); h_data = int'(out_data); h_last = out_last;
        if (out_valid && out_ready) begin
            if (eh == et) begin
                chk(0, "R4 stray word", int'(out_addr), -1);
            end else begin
                chk(int'(out_addr) == exp_addr[eh], {exp_tag[eh], " addr"}, int'(out_addr), exp_addr[eh]);
                chk(int'(out_data) == exp_data[eh], {exp_tag[eh], " data"}, int'(out_data), exp_data[eh]);
                chk(out_last == exp_last[eh], "R5 last flag", int'(out_last), int'(exp_last[eh]));
                eh++;
            end
        end
        if (!busy) widx++;
        ncyc++;
        @(negedge clk);
        trig = 1'b0;
    endtask

    // Trigger now; if accepted, queue the expected window.
    task automatic fire(input bit accept, input string tag);
        int tp, n, pk, best;
        tp = widx; n = int'(cfg_span); best = -1; pk = 0;
        if (accept) begin
            for (int j = tp - n; j < tp; j++) begin
                if (fval(j) > best) begin best = fval(j); pk = j; end
            end
            for (int k = -int'(cfg_pre); k <= int'(cfg_post); k++) begin
                exp_addr[et] = (pk + k) % 2048;
                exp_data[et] = fval(pk + k);
                exp_last[et] = (k == int'(cfg_post));
                exp_tag[et]  = tag;
                et++;
            end
        end
        cyc(1'b1);
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        while ((eh != et || out_valid) && guard < 4000) begin cyc(1'b0); guard++; end
        repeat (4) cyc(1'b0);
        chk(eh == et && !out_valid, "R4 window complete", et - eh, 0);
    endtask

    task automatic set_cfg(input int n, input int pr, input int po);
        cfg_span = 7'(n); cfg_pre = 6'(pr); cfg_post = 6'(po);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", ncyc, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int wstop;
        rst_n = 1'b0; smp_valid = 1'b0; trig = 1'b0; out_ready = 1'b0;
        smp_data = '0; set_cfg(4, 1, 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!out_valid, "R1 out_valid", int'(out_valid), 0);
        chk(!busy, "R1 busy", int'(busy), 0);
        chk(lost_cnt == 0, "R1 lost_cnt", int'(lost_cnt), 0);

        repeat (200) cyc(1'b0);

        // R3 / R4 / R10 / R6: sweep span, pre and post
        for (int si = 0; si < 3; si++) begin
            for (int pi = 0; pi < 2; pi++) begin
                for (int qi = 0; qi < 2; qi++) begin
                    set_cfg((si == 0) ? 1 : (si == 1) ? 7 : 64, pi * 5, qi * 9);
                    rdy_mode = (si + pi + qi) % 2;
                    repeat (3) cyc(1'b0);
                    if (si == 0 && qi == 1) fire(1'b1, "R10 window ahead of writer");
                    else if (si == 2)       fire(1'b1, "R3 tie peak");
                    else                    fire(1'b1, "R4 window");
                    drain();
                end
            end
        end

        // R2: search span wraps through address 0
        rdy_mode = 0;
        set_cfg(64, 10, 10);
        while (!(widx % 2048 == 20 && widx > 2048)) cyc(1'b0);
        fire(1'b1, "R2 span wrap");
        drain();

        // R2: window end wraps past address 2047
        set_cfg(4, 2, 20);
        while (widx % 2048 != 2044) cyc(1'b0);
        fire(1'b1, "R2 window wrap");
        drain();

        // R7 / R8: queued event and a lost trigger
        set_cfg(8, 2, 3);
        rdy_mode = 1;
        fire(1'b1, "R8 first event");
        cyc(1'b0);
        fire(1'b1, "R8 queued event");
        fire(1'b0, "R7 dropped");
        chk(lost_cnt == 1, "R7 lost count", int'(lost_cnt), 1);
        drain();

        // R9 / R7: consumer stalled, ring fills, writer must stop
        set_cfg(16, 4, 4);
        rdy_mode = 2;
        repeat (100) cyc(1'b0);
        wstop = widx;
        fire(1'b1, "R9 held event");
        fire(1'b1, "R9 held queued event");
        repeat (300) fire(1'b0, "R7 dropped");
        chk(lost_cnt == 255, "R7 lost saturation", int'(lost_cnt), 255);
        for (int g = 0; g < 2300 && !busy; g++) cyc(1'b0);
        chk(busy, "R9 busy raised", int'(busy), 1);
        chk(widx - wstop == 2047 - 16 - 4, "R9 accepted before stall", widx - wstop, 2027);
        repeat (50) cyc(1'b0);
        chk(widx - wstop == 2027, "R9 samples dropped while busy", widx - wstop, 2027);
        rdy_mode = 0;
        drain();
        chk(!busy, "R9 busy cleared", int'(busy), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule